// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block drives one switching channel of a synchronous power stage. It turns a decoded PWM request into two enables, one for the high-side gate and one for the low-side gate, and it never allows both switches to conduct. Before either gate is switched on, the block waits until the opposite gate reports that it has discharged below its turn-on threshold. It then adds a short fixed margin. The dead time therefore follows the real discharge speed of the switches fitted rather than a fixed worst-case count. Every delay is a parameter counted in clock cycles.

The PWM request arrives already decoded into a level bit and a mid-level bit. The mid-level bit marks the tri-state shutdown window. Entering the window switches off whichever gate was on. Staying in the window past a holdoff count parks the stage: both gates are held low until the window is left, and the gate matching the new level then comes back after an exit delay. A current-balance extension, given as an extra cycle count, lengthens the high-side turn-off delay. If a discharge flag fails to arrive within a timeout, the stage is made safe and a sticky fault is raised. Only reset clears it.

All inputs pass through one register stage before the sequencer sees them. The latencies below count that stage. Each one is measured from the clock edge that first samples the new input value.

Top module: `gate_dt_sequencer`

## Requirements
- R1: While reset is asserted, and straight after it, hi_en=0, lo_en=0, parked=1 and fault=0.
- R2: With lo_en=1 and pwm_mid=0, a change of pwm_level to 1 makes lo_en fall T_OFF+1 cycles after the sampling edge. hi_en stays 0 throughout.
- R3: hi_en rises only after lo_en is off and lo_gate_low (1 = low-side gate discharged) has been sampled high. The rise comes T_HI_ON+1 cycles after that sampling edge.
- R4: With hi_en=1, a change of pwm_level to 0 makes hi_en fall T_OFF+bal_ext+1 cycles after the sampling edge. bal_ext is sampled on the same edge as the level.
- R5: lo_en rises only after hi_en is off and hi_gate_low has been sampled high. The rise comes T_LO_ON+1 cycles after that sampling edge.
- R6: hi_en and lo_en are never 1 in the same cycle.
- R7: pwm_mid=1 means the tri-state window and overrides pwm_level. Whichever gate was on goes off 1 cycle after the sampling edge.
- R8: If pwm_mid stays 1 for T_HOLD cycles after the gates go off, parked rises and both gates stay off until pwm_mid returns to 0. A shorter window never raises parked.
- R9: When pwm_mid returns to 0 and the gate opposite the requested level already reports discharged, the requested gate turns on T_EXIT+1 cycles after the sampling edge. parked falls 1 cycle after that edge.
- R10: A pwm_level pulse that reverses before the turn-off delay ends leaves the conducting gate on without a break.
- R11: If the awaited discharge flag is not seen within TMO cycles after a gate turns off, fault rises TMO cycles after the turn-off. Both gates then stay off and all inputs are ignored until reset. A flag seen in the same cycle as the last timeout count takes priority, and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_level | input | 1 | Decoded PWM level, 1 = request high-side on |
| pwm_mid | input | 1 | 1 = PWM inside the tri-state window; overrides pwm_level |
| bal_ext | input | EXT_W | Extra high-side turn-off cycles from current balance |
| hi_gate_low | input | 1 | 1 = high-side gate discharged below threshold |
| lo_gate_low | input | 1 | 1 = low-side gate discharged below threshold |
| hi_en | output | 1 | High-side gate enable |
| lo_en | output | 1 | Low-side gate enable |
| parked | output | 1 | Both gates held low after the tri-state holdoff |
| fault | output | 1 | Sticky discharge-timeout fault |

## Verification
The two functions that can land on the same clock edge are the arrival of a discharge flag and the expiry of the discharge timeout. The bench provokes the collision by making its low-side gate model report discharge exactly TMO-1 cycles after release. The flag is then sampled on the edge where the timeout count reaches its limit. The run passes when no fault appears and the high side turns on with the normal margin. A second run, with the flag withheld, must raise the fault at exactly TMO cycles.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [3:0] {
        ST_PARK,
        ST_HOLD,
        ST_EXIT,
        ST_LO_ON,
        ST_LO_OFFDLY,
        ST_WAIT_LO,
        ST_HI_ONDLY,
        ST_HI_ON,
        ST_HI_OFFDLY,
        ST_WAIT_HI,
        ST_LO_ONDLY,
        ST_FAULT
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic hi_drive(input seq_state_e s);
        return (s == ST_HI_ON) || (s == ST_HI_OFFDLY);
    endfunction

    function automatic logic lo_drive(input seq_state_e s);
        return (s == ST_LO_ON) || (s == ST_LO_OFFDLY);
    endfunction

endpackage

// File: rtl/gs_in_stage.sv
module gs_in_stage #(
    parameter int EXT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_level,
    input  logic             pwm_mid,
    input  logic [EXT_W-1:0] bal_ext,
    input  logic             hi_gate_low,
    input  logic             lo_gate_low,
    output logic             want_hi_q,
    output logic             mid_q,
    output logic [EXT_W-1:0] ext_q,
    output logic             hi_low_q,
    output logic             lo_low_q
);

    typedef struct packed {
        logic             lvl;
        logic             mid;
        logic             hi_low;
        logic             lo_low;
        logic [EXT_W-1:0] ext;
    } in_t;

    in_t in_d, in_q;

    always_comb begin
        in_d.lvl    = pwm_level;
        in_d.mid    = pwm_mid;
        in_d.hi_low = hi_gate_low;
        in_d.lo_low = lo_gate_low;
        in_d.ext    = bal_ext;
    end

    // Reset reads as "inside the window" so the sequencer starts parked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q     <= '0;
            in_q.mid <= 1'b1;
        end else begin
            in_q <= in_d;
        end
    end

    assign want_hi_q = in_q.lvl;
    assign mid_q     = in_q.mid;
    assign ext_q     = in_q.ext;
    assign hi_low_q  = in_q.hi_low;
    assign lo_low_q  = in_q.lo_low;

endmodule

// File: rtl/gs_step_counter.sv
module gs_step_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_TOP) begin
            cnt_d = cnt_q + W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
    import gs_pkg::*;
#(
    parameter int T_OFF   = 10,
    parameter int T_HI_ON = 6,
    parameter int T_LO_ON = 5,
    parameter int T_HOLD  = 6,
    parameter int T_EXIT  = 6,
    parameter int TMO     = 64,
    parameter int EXT_W   = 4,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_hi,
    input  logic             mid,
    input  logic [EXT_W-1:0] ext,
    input  logic             hi_low,
    input  logic             lo_low,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             hi_en,
    output logic             lo_en,
    output logic             parked,
    output logic             fault
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] lim;
        logic             hi;
        logic             lo;
        logic             park;
        logic             flt;
    } seq_t;

    localparam logic [CNT_W-1:0] LIM_OFF   = CNT_W'(T_OFF);
    localparam logic [CNT_W-1:0] LIM_HI_ON = CNT_W'(T_HI_ON);
    localparam logic [CNT_W-1:0] LIM_LO_ON = CNT_W'(T_LO_ON);
    localparam logic [CNT_W-1:0] LIM_HOLD  = CNT_W'(T_HOLD);
    localparam logic [CNT_W-1:0] LIM_EXIT  = CNT_W'(T_EXIT);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO - 1);

    seq_t cur_q, nx_d;
    logic dly_done;
    logic tmo_hit;

    assign dly_done = (cnt == (cur_q.lim - CNT_W'(1)));
    assign tmo_hit  = (cnt == TMO_LAST);

    always_comb begin
        nx_d = cur_q;
        unique case (cur_q.st)
            ST_PARK: begin
                if (!mid) begin
                    nx_d.st  = ST_EXIT;
                    nx_d.lim = LIM_EXIT;
                end
            end
            ST_HOLD: begin
                if (!mid) begin
                    nx_d.st  = ST_EXIT;
                    nx_d.lim = LIM_EXIT;
                end else if (dly_done) begin
                    nx_d.st = ST_PARK;
                end
            end
            ST_EXIT: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (dly_done) begin
                    if (want_hi) begin
                        nx_d.st = lo_low ? ST_HI_ON : ST_WAIT_LO;
                    end else begin
                        nx_d.st = hi_low ? ST_LO_ON : ST_WAIT_HI;
                    end
                end
            end
            ST_LO_ON: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (want_hi) begin
                    nx_d.st  = ST_LO_OFFDLY;
                    nx_d.lim = LIM_OFF;
                end
            end
            ST_LO_OFFDLY: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (!want_hi) begin
                    nx_d.st = ST_LO_ON;
                end else if (dly_done) begin
                    nx_d.st = ST_WAIT_LO;
                end
            end
            ST_WAIT_LO: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (!want_hi) begin
                    nx_d.st = ST_WAIT_HI;
                end else if (lo_low) begin
                    nx_d.st  = ST_HI_ONDLY;
                    nx_d.lim = LIM_HI_ON;
                end else if (tmo_hit) begin
                    nx_d.st = ST_FAULT;
                end
            end
            ST_HI_ONDLY: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (!want_hi) begin
                    nx_d.st = ST_WAIT_HI;
                end else if (dly_done) begin
                    nx_d.st = ST_HI_ON;
                end
            end
            ST_HI_ON: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (!want_hi) begin
                    nx_d.st  = ST_HI_OFFDLY;
                    nx_d.lim = LIM_OFF + CNT_W'(ext);
                end
            end
            ST_HI_OFFDLY: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (want_hi) begin
                    nx_d.st = ST_HI_ON;
                end else if (dly_done) begin
                    nx_d.st = ST_WAIT_HI;
                end
            end
            ST_WAIT_HI: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (want_hi) begin
                    nx_d.st = ST_WAIT_LO;
                end else if (hi_low) begin
                    nx_d.st  = ST_LO_ONDLY;
                    nx_d.lim = LIM_LO_ON;
                end else if (tmo_hit) begin
                    nx_d.st = ST_FAULT;
                end
            end
            ST_LO_ONDLY: begin
                if (mid) begin
                    nx_d.st  = ST_HOLD;
                    nx_d.lim = LIM_HOLD;
                end else if (want_hi) begin
                    nx_d.st = ST_WAIT_LO;
                end else if (dly_done) begin
                    nx_d.st = ST_LO_ON;
                end
            end
            ST_FAULT: begin
                nx_d.st = ST_FAULT;
            end
            default: begin
                nx_d.st = ST_FAULT;
            end
        endcase

        nx_d.hi   = hi_drive(nx_d.st);
        nx_d.lo   = lo_drive(nx_d.st);
        nx_d.park = (nx_d.st == ST_PARK);
        nx_d.flt  = (nx_d.st == ST_FAULT);
    end

    assign cnt_clr = (nx_d.st != cur_q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.st   <= ST_PARK;
            cur_q.lim  <= LIM_HOLD;
            cur_q.park <= 1'b1;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign hi_en  = cur_q.hi;
    assign lo_en  = cur_q.lo;
    assign parked = cur_q.park;
    assign fault  = cur_q.flt;

    a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_en));

    a_r3_hi_after_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> !$past(lo_en));

    a_r5_lo_after_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> !$past(hi_en));

    a_r7_mid_kills_gates: assert property (@(posedge clk) disable iff (!rst_n)
        mid |=> (!hi_en && !lo_en));

    a_r8_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> (!hi_en && !lo_en && !fault));

    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && !hi_en && !lo_en));

endmodule

// File: rtl/gate_dt_sequencer.sv
module gate_dt_sequencer
    import gs_pkg::*;
#(
    parameter int T_OFF   = 10,
    parameter int T_HI_ON = 6,
    parameter int T_LO_ON = 5,
    parameter int T_HOLD  = 6,
    parameter int T_EXIT  = 6,
    parameter int TMO     = 64,
    parameter int EXT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_level,
    input  logic             pwm_mid,
    input  logic [EXT_W-1:0] bal_ext,
    input  logic             hi_gate_low,
    input  logic             lo_gate_low,
    output logic             hi_en,
    output logic             lo_en,
    output logic             parked,
    output logic             fault
);

    localparam int LIM_MAX  = T_OFF + (1 << EXT_W) - 1;
    localparam int FIX_MAX  = imax(imax(T_HI_ON, T_LO_ON), imax(T_HOLD, T_EXIT));
    localparam int CNT_SPAN = imax(imax(LIM_MAX, FIX_MAX), TMO);
    localparam int CNT_W    = $clog2(CNT_SPAN + 1);

    logic             want_hi_q;
    logic             mid_q;
    logic [EXT_W-1:0] ext_q;
    logic             hi_low_q;
    logic             lo_low_q;
    logic [CNT_W-1:0] step_cnt;
    logic             step_clr;

    gs_in_stage #(
        .EXT_W(EXT_W)
    ) u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_level  (pwm_level),
        .pwm_mid    (pwm_mid),
        .bal_ext    (bal_ext),
        .hi_gate_low(hi_gate_low),
        .lo_gate_low(lo_gate_low),
        .want_hi_q  (want_hi_q),
        .mid_q      (mid_q),
        .ext_q      (ext_q),
        .hi_low_q   (hi_low_q),
        .lo_low_q   (lo_low_q)
    );

    gs_step_counter #(
        .W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (step_clr),
        .count(step_cnt)
    );

    gs_seq_fsm #(
        .T_OFF  (T_OFF),
        .T_HI_ON(T_HI_ON),
        .T_LO_ON(T_LO_ON),
        .T_HOLD (T_HOLD),
        .T_EXIT (T_EXIT),
        .TMO    (TMO),
        .EXT_W  (EXT_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_hi(want_hi_q),
        .mid    (mid_q),
        .ext    (ext_q),
        .hi_low (hi_low_q),
        .lo_low (lo_low_q),
        .cnt    (step_cnt),
        .cnt_clr(step_clr),
        .hi_en  (hi_en),
        .lo_en  (lo_en),
        .parked (parked),
        .fault  (fault)
    );

endmodule

// File: tb/gate_dt_sequencer_bench.sv
module gate_dt_sequencer_bench;

    localparam int T_OFF   = 10;
    localparam int T_HI_ON = 6;
    localparam int T_LO_ON = 5;
    localparam int T_HOLD  = 6;
    localparam int T_EXIT  = 6;
    localparam int TMO     = 64;
    localparam int EXT_W   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwm_level = 1'b0;
    logic             pwm_mid = 1'b0;
    logic [EXT_W-1:0] bal_ext = '0;
    logic             hi_gate_low = 1'b0;
    logic             lo_gate_low = 1'b0;
    logic             hi_en, lo_en, parked, fault;

    gate_dt_sequencer #(
        .T_OFF(T_OFF), .T_HI_ON(T_HI_ON), .T_LO_ON(T_LO_ON),
        .T_HOLD(T_HOLD), .T_EXIT(T_EXIT), .TMO(TMO), .EXT_W(EXT_W)
    ) u_gate_dt_sequencer (
        .clk(clk), .rst_n(rst_n), .pwm_level(pwm_level), .pwm_mid(pwm_mid),
        .bal_ext(bal_ext), .hi_gate_low(hi_gate_low), .lo_gate_low(lo_gate_low),
        .hi_en(hi_en), .lo_en(lo_en), .parked(parked), .fault(fault)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Gate discharge models and output monitor
    int hi_dis = 2, lo_dis = 2;
    bit hi_stuck = 1'b0, lo_stuck = 1'b0;
    int hi_cnt = 0, lo_cnt = 0;
    logic p_hi = 1'b0, p_lo = 1'b0, p_pk = 1'b0, p_ft = 1'b0;
    int t_hi_rise = -1, t_hi_fall = -1, t_lo_rise = -1, t_lo_fall = -1;
    int t_pk_rise = -1, t_pk_fall = -1, t_ft_rise = -1;
    int n_hi_fall = 0, n_lo_fall = 0, n_pk_rise = 0, n_overlap = 0;
    int t_drv = 0;

    always @(negedge clk) begin
        if (hi_en) begin
            hi_cnt = 0;
            hi_gate_low = 1'b0;
        end else begin
            if (hi_cnt < 1000) hi_cnt = hi_cnt + 1;
            hi_gate_low = !hi_stuck && (hi_cnt >= hi_dis);
        end
        if (lo_en) begin
            lo_cnt = 0;
            lo_gate_low = 1'b0;
        end else begin
            if (lo_cnt < 1000) lo_cnt = lo_cnt + 1;
            lo_gate_low = !lo_stuck && (lo_cnt >= lo_dis);
        end
        if (hi_en && !p_hi) t_hi_rise = cyc;
        if (!hi_en && p_hi) begin t_hi_fall = cyc; n_hi_fall++; end
        if (lo_en && !p_lo) t_lo_rise = cyc;
        if (!lo_en && p_lo) begin t_lo_fall = cyc; n_lo_fall++; end
        if (parked && !p_pk) begin t_pk_rise = cyc; n_pk_rise++; end
        if (!parked && p_pk) t_pk_fall = cyc;
        if (fault && !p_ft) t_ft_rise = cyc;
        if (hi_en && lo_en) n_overlap++;
        p_hi = hi_en; p_lo = lo_en; p_pk = parked; p_ft = fault;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic waitcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic lvl, input logic md, input logic [EXT_W-1:0] e);
        @(negedge clk);
        pwm_level = lvl;
        pwm_mid   = md;
        bal_ext   = e;
        t_drv     = cyc;
    endtask

    // R2, R3: low side released, high side after discharge plus margin
    task automatic t_rise(input int ldis);
        lo_dis = ldis;
        drive(1'b1, 1'b0, '0);
        waitcyc(ldis + T_OFF + T_HI_ON + 12);
        chk_eq("R2 lo off delay", t_lo_fall - t_drv, T_OFF + 2);
        chk_eq("R3 dead time lo->hi", t_hi_rise - t_lo_fall, ldis + 1 + T_HI_ON);
    endtask

    // R4, R5: high side released after delay plus extension, low side after margin
    task automatic t_fall(input int e);
        hi_dis = 2;
        drive(1'b0, 1'b0, EXT_W'(e));
        waitcyc(T_OFF + e + T_LO_ON + 20);
        chk_eq("R4 hi off delay", t_hi_fall - t_drv, T_OFF + e + 2);
        chk_eq("R5 dead time hi->lo", t_lo_rise - t_hi_fall, 2 + 1 + T_LO_ON);
    endtask

    // R10: pulses shorter than the off delay leave the conducting gate on
    task automatic t_short_lo();
        int n0;
        n0 = n_lo_fall;
        drive(1'b1, 1'b0, '0);
        waitcyc(4);
        drive(1'b0, 1'b0, '0);
        waitcyc(25);
        chk_eq("R10 lo kept through short high pulse", n_lo_fall, n0);
        chk_eq("R10 lo still on", int'(lo_en), 1);
    endtask

    task automatic t_short_hi();
        int n0;
        n0 = n_hi_fall;
        drive(1'b0, 1'b0, '0);
        waitcyc(4);
        drive(1'b1, 1'b0, '0);
        waitcyc(25);
        chk_eq("R10 hi kept through short low pulse", n_hi_fall, n0);
        chk_eq("R10 hi still on", int'(hi_en), 1);
    endtask

    // R7, R8, R9: short window: gate off, no park, comes back after exit delay
    task automatic t_tri_short();
        int c0, c1, np;
        np = n_pk_rise;
        drive(1'b0, 1'b1, '0);
        c0 = t_drv;
        waitcyc(3);
        drive(1'b0, 1'b0, '0);
        c1 = t_drv;
        waitcyc(20);
        chk_eq("R7 lo off on window entry", t_lo_fall - c0, 2);
        chk_eq("R8 short window does not park", n_pk_rise, np);
        chk_eq("R9 lo back after exit", t_lo_rise - c1, T_EXIT + 2);
    endtask

    // R7, R8, R9: long window parks; level changes inside are ignored
    task automatic t_tri_long();
        int c0, c1;
        drive(1'b1, 1'b1, '0);
        c0 = t_drv;
        waitcyc(12);
        chk_eq("R7 hi off on window entry", t_hi_fall - c0, 2);
        chk_eq("R8 park after holdoff", t_pk_rise - t_hi_fall, T_HOLD);
        drive(1'b0, 1'b1, '0);
        waitcyc(5);
        drive(1'b1, 1'b1, '0);
        waitcyc(5);
        chk(!hi_en && !lo_en && parked, "R7 level ignored inside window",
            {hi_en, lo_en, parked}, 3'b001);
        drive(1'b1, 1'b0, '0);
        c1 = t_drv;
        waitcyc(20);
        chk_eq("R9 hi back after exit", t_hi_rise - c1, T_EXIT + 2);
        chk_eq("R9 parked falls on exit", t_pk_fall - c1, 2);
    endtask

    // R11: flag in the timeout cycle wins
    task automatic t_race();
        lo_dis = TMO - 1;
        drive(1'b1, 1'b0, '0);
        waitcyc(T_OFF + TMO + T_HI_ON + 10);
        chk_eq("R11 flag beats timeout, no fault", int'(fault), 0);
        chk_eq("R11 hi rises after late flag", t_hi_rise - t_lo_fall, TMO + T_HI_ON);
        lo_dis = 2;
    endtask

    // R11: missing flag raises a sticky fault
    task automatic t_timeout();
        lo_stuck = 1'b1;
        drive(1'b1, 1'b0, '0);
        waitcyc(T_OFF + TMO + 10);
        chk_eq("R11 lo off delay before fault", t_lo_fall - t_drv, T_OFF + 2);
        chk_eq("R11 fault after timeout", t_ft_rise - t_lo_fall, TMO);
        chk_eq("R11 hi not enabled", int'(hi_en), 0);
        lo_stuck = 1'b0;
        drive(1'b0, 1'b0, '0);
        waitcyc(10);
        drive(1'b0, 1'b1, '0);
        waitcyc(3);
        drive(1'b1, 1'b0, '0);
        waitcyc(20);
        chk(fault && !hi_en && !lo_en, "R11 fault holds, inputs ignored",
            {fault, hi_en, lo_en}, 3'b100);
    endtask

    task automatic check_reset_state(input string tag);
        chk_eq({tag, " hi_en"}, int'(hi_en), 0);
        chk_eq({tag, " lo_en"}, int'(lo_en), 0);
        chk_eq({tag, " parked"}, int'(parked), 1);
        chk_eq({tag, " fault"}, int'(fault), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        waitcyc(5);
        check_reset_state("R1 reset");
        @(negedge clk) rst_n = 1'b1;
        waitcyc(20);
        chk(lo_en && !hi_en && !parked, "R9 lo on after reset release",
            {lo_en, hi_en, parked}, 3'b100);

        t_rise(3);
        t_fall(0);
        t_rise(1);
        t_fall(7);
        t_short_lo();
        t_rise(2);
        t_short_hi();
        t_fall(0);
        t_tri_short();
        t_rise(2);
        t_tri_long();
        t_fall(0);
        t_race();
        t_fall(0);
        t_timeout();

        @(negedge clk) rst_n = 1'b0;
        pwm_level = 1'b0;
        pwm_mid   = 1'b0;
        waitcyc(3);
        check_reset_state("R1 reset clears fault");
        @(negedge clk) rst_n = 1'b1;
        waitcyc(20);
        chk_eq("R1 lo on after second reset", int'(lo_en), 1);

        chk_eq("R6 overlap cycles", n_overlap, 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule